// File: doc/BRIEF.md
# Serial Port Interrupt Cause Resolver

This block picks the one interrupt cause a PC-style serial port reports to the processor at any moment. Four conditions can compete: a receive overrun, unread receive data, a pending transmit-empty event, and a modem status change. Each is gated by its own bit of the interrupt enable register (IER), which this block stores. The surviving cause with the highest rank becomes the reason code in the interrupt identification byte (IIR), and the interrupt request line is raised whenever a cause survives.

The overrun, receive-non-empty and modem-delta conditions come in as levels from the rest of the port. The transmit-empty condition is a flag owned here. A data-register write sets it. An IER write that turns the transmit enable on also sets it. An IIR read clears it, but only when that read actually reports transmit-empty. FIFO storage, bit timing and character-timeout counting sit outside the block. Unread receive data is always reported with the character-timeout code.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the stored IER is 0x00, the transmit-empty flag is clear, the IIR byte reads 0x01 and the interrupt line is low.
- R2: An IER write stores only bits 0 to 3 of the written byte; bits 7 to 4 of the IER output read as zero. The write is visible from the cycle after the strobe.
- R3: The reason is chosen in this rank, highest first: overrun with IER bit 2 (code 0x6), receive data with IER bit 0, transmit-empty flag with IER bit 1 (code 0x2), modem delta with IER bit 3 (code 0x0). When no enabled cause is active the code is 0x1. The code sits in IIR bits 3 to 0.
- R4: Unread receive data is reported with code 0xC.
- R5: A data-register write strobe sets the transmit-empty flag from the next cycle.
- R6: An IER write whose bit 1 is 1 sets the transmit-empty flag only if the stored IER bit 1 was 0. Rewriting it while it is already 1 leaves the flag alone.
- R7: An IIR read strobe clears the transmit-empty flag from the next cycle only when the reported code in that cycle is 0x2. Any other reported code leaves the flag unchanged.
- R8: When FIFO mode is on, IIR bits 7 and 6 are 1. When it is off they are 0. Bits 5 and 4 are always 0.
- R9: The interrupt line is high exactly when the reported code is not 0x1. It follows the level inputs in the same cycle.
- R10: If a data write and an IIR read reporting 0x2 come in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| overrun_i | input | 1 | Receive overrun condition |
| rx_avail_i | input | 1 | Receive storage holds at least one character |
| msr_delta_i | input | 1 | Any modem status change pending |
| fifo_mode_i | input | 1 | FIFO mode enabled |
| data_wr_i | input | 1 | Data register write strobe |
| ier_wr_i | input | 1 | IER write strobe |
| ier_wdata_i | input | 8 | IER write data |
| iir_rd_i | input | 1 | IIR read strobe |
| ier_o | output | 8 | Stored IER, upper nibble zero |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong transmit-empty flag appears at the ports in the cycle after the strobe that mishandles it. It shows as code 0x2 when a 0x1 was due, or 0x1 when a 0x2 was due, but only while IER bit 1 is set and no higher cause is active. That is why the flag tests mask the higher causes. A rank or gating error shows at once as a wrong IIR nibble and a wrong interrupt level under the overlapping input patterns. A mis-stored IER shows on ier_o in the cycle after the write.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int N_CAUSE = 4;
  localparam int IER_W   = 4;
  localparam int BYTE_W  = 8;

  // cause index: 0 = overrun, 1 = rx data, 2 = tx empty, 3 = modem
  localparam int C_LINE  = 0;
  localparam int C_RX    = 1;
  localparam int C_TXE   = 2;
  localparam int C_MODEM = 3;

  typedef enum logic [3:0] {
    RSN_MODEM = 4'h0,
    RSN_NONE  = 4'h1,
    RSN_TXE   = 4'h2,
    RSN_LINE  = 4'h6,
    RSN_TMO   = 4'hC
  } rsn_e;

  function automatic rsn_e cause_code(input int idx);
    case (idx)
      C_LINE:  return RSN_LINE;
      C_RX:    return RSN_TMO;
      C_TXE:   return RSN_TXE;
      default: return RSN_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uirq_ier_reg.sv
module uirq_ier_reg
  import uirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [IER_W-1:0]  ier_o,
  output logic              txe_rise_o
);
  logic [IER_W-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_q <= '0;
    else if (wr_i) ier_q <= wdata_i[IER_W-1:0];
  end

  assign ier_o      = ier_q;
  assign txe_rise_o = wr_i & wdata_i[1] & ~ier_q[1];

  AST_IER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ier_q == $past(wdata_i[IER_W-1:0])); // R2
  AST_IER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ier_q)); // R2
endmodule

// File: rtl/uirq_txe_flag.sv
module uirq_txe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // set beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_TXE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q); // R5
  AST_TXE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_q); // R7
  AST_TXE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q); // R7
endmodule

// File: rtl/uirq_resolver.sv
module uirq_resolver
  import uirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] raw_i,
  input  logic [N_CAUSE-1:0] en_i,
  output logic [N_CAUSE-1:0] sel_o,
  output rsn_e               rsn_o
);
  logic [N_CAUSE-1:0] act;
  logic               found;

  assign act = raw_i & en_i;

  always_comb begin
    sel_o = '0;
    rsn_o = RSN_NONE;
    found = 1'b0;
    for (int i = 0; i < N_CAUSE; i++) begin
      if (act[i] && !found) begin
        sel_o[i] = 1'b1;
        rsn_o    = cause_code(i);
        found    = 1'b1;
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R3
  AST_LINE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i[C_LINE] && en_i[C_LINE]) |-> rsn_o == RSN_LINE); // R3
  AST_IDLE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0) |-> rsn_o == RSN_NONE); // R3
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              overrun_i,
  input  logic              rx_avail_i,
  input  logic              msr_delta_i,
  input  logic              fifo_mode_i,
  input  logic              data_wr_i,
  input  logic              ier_wr_i,
  input  logic [BYTE_W-1:0] ier_wdata_i,
  input  logic              iir_rd_i,
  output logic [BYTE_W-1:0] ier_o,
  output logic [BYTE_W-1:0] iir_o,
  output logic              irq_o
);
  localparam int PAD_W = BYTE_W - IER_W;

  logic [IER_W-1:0]   ier;
  logic               txe_rise;
  logic               txe_pend;
  logic [N_CAUSE-1:0] raw, en, sel;
  rsn_e               rsn;

  uirq_ier_reg u_ier (
    .clk_i, .rst_ni,
    .wr_i       (ier_wr_i),
    .wdata_i    (ier_wdata_i),
    .ier_o      (ier),
    .txe_rise_o (txe_rise)
  );

  uirq_txe_flag u_txe (
    .clk_i, .rst_ni,
    .set_i  (data_wr_i | txe_rise),
    .clr_i  (iir_rd_i & sel[C_TXE]),
    .pend_o (txe_pend)
  );

  always_comb begin
    raw[C_LINE]  = overrun_i;   en[C_LINE]  = ier[2];
    raw[C_RX]    = rx_avail_i;  en[C_RX]    = ier[0];
    raw[C_TXE]   = txe_pend;    en[C_TXE]   = ier[1];
    raw[C_MODEM] = msr_delta_i; en[C_MODEM] = ier[3];
  end

  uirq_resolver u_res (
    .clk_i, .rst_ni,
    .raw_i (raw),
    .en_i  (en),
    .sel_o (sel),
    .rsn_o (rsn)
  );

  assign ier_o = {{PAD_W{1'b0}}, ier};
  assign iir_o = {{2{fifo_mode_i}}, 2'b00, rsn};
  assign irq_o = (rsn != RSN_NONE);

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1)); // R9
  AST_IER_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> ier_o[BYTE_W-1:IER_W] == '0); // R2
endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovr = 0, rxa = 0, dlt = 0, fifo = 0;
  logic       dwr = 0, iwr = 0, ird = 0;
  logic [7:0] iwd = 0;
  logic [7:0] ier_o, iir_o;
  logic       irq_o;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_prio u0 (
    .clk_i(clk), .rst_ni(rst_n), .overrun_i(ovr), .rx_avail_i(rxa),
    .msr_delta_i(dlt), .fifo_mode_i(fifo), .data_wr_i(dwr),
    .ier_wr_i(iwr), .ier_wdata_i(iwd), .iir_rd_i(ird),
    .ier_o(ier_o), .iir_o(iir_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] exp_iir);
    logic exp_irq = (exp_iir[3:0] != 4'h1);
    n_chk++;
    if (iir_o !== exp_iir || irq_o !== exp_irq) begin
      n_bad++;
      $display("FAIL %s iir=%02h irq=%0b expected iir=%02h irq=%0b",
               req, iir_o, irq_o, exp_iir, exp_irq);
    end
  endtask

  task automatic chk_ier(input string req, input logic [7:0] exp);
    n_chk++;
    if (ier_o !== exp) begin
      n_bad++;
      $display("FAIL %s ier=%02h expected %02h", req, ier_o, exp);
    end
  endtask

  // strobes driven after a negedge, held across one posedge
  task automatic wr_ier(input logic [7:0] v);
    iwd = v; iwr = 1; @(negedge clk); iwr = 0;
  endtask
  task automatic wr_data();
    dwr = 1; @(negedge clk); dwr = 0;
  endtask
  task automatic rd_iir();
    ird = 1; @(negedge clk); ird = 0;
  endtask
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", 8'h01);
    chk_ier("R1", 8'h00);
  endtask

  task automatic t_ier_mask();
    wr_ier(8'hF5);
    chk_ier("R2", 8'h05);
    wr_ier(8'h00);
    chk_ier("R2", 8'h00);
    chk("R2", 8'h01);
  endtask

  task automatic t_rx_code();
    wr_ier(8'h01);
    rxa = 1; #1; chk("R4", 8'h0C);
    rxa = 0; #1; chk("R9", 8'h01);
    settle();
  endtask

  task automatic t_priority();
    ovr = 1; rxa = 1; dlt = 1;
    wr_ier(8'h0F);               // rising tx enable sets flag
    chk("R3", 8'h06);
    ovr = 0; #1; chk("R3", 8'h0C);
    rxa = 0; #1; chk("R3", 8'h02);
    rd_iir();
    chk("R7", 8'h00);
    dlt = 0; #1; chk("R3", 8'h01);
    wr_data();
    ovr = 1; rxa = 1; dlt = 1;
    wr_ier(8'h00); chk("R3", 8'h01);
    ovr = 0; rxa = 0; dlt = 0;
    settle();
  endtask

  task automatic t_read_other();
    wr_ier(8'h03);               // flag set, rx enabled
    rxa = 1; #1; chk("R7", 8'h0C);
    rd_iir();                    // reports 0xC, flag must stay
    rxa = 0; #1; chk("R7", 8'h02);
    rd_iir();
    chk("R7", 8'h01);
    rd_iir();                    // reports none, nothing to change
    chk("R7", 8'h01);
  endtask

  task automatic t_ier_edge();
    wr_ier(8'h02);               // bit1 already set: no edge
    chk("R6", 8'h01);
    wr_ier(8'h00);
    wr_ier(8'h02);
    chk("R6", 8'h02);
    rd_iir();
    chk("R6", 8'h01);
  endtask

  task automatic t_data_wr();
    wr_data();
    chk("R5", 8'h02);
    dwr = 1; ird = 1; @(negedge clk); dwr = 0; ird = 0;
    chk("R10", 8'h02);
    rd_iir();
    chk("R10", 8'h01);
  endtask

  task automatic t_fifo();
    fifo = 1; #1; chk("R8", 8'hC1);
    wr_data();
    chk("R8", 8'hC2);
    rd_iir();
    chk("R8", 8'hC1);
    fifo = 0; #1; chk("R8", 8'h01);
    settle();
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ier_mask();
    t_rx_code();
    t_priority();
    t_read_other();
    t_ier_edge();
    t_data_wr();
    t_fifo();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule